// File: doc/BRIEF.md
# Four-Phase Request/Acknowledge Bus Controller Pair

This block pairs a bus master controller with a register-file bus target. The two are joined by a fully interlocked four-phase request/acknowledge handshake. The handshake is modelled synchronously: each side samples the other side's strobe through a synchronizer chain and reacts to the sampled level.

A local command port on the master accepts one read or write at a time. The master places the address, direction and write data on the bus first. It then waits a programmable number of settling cycles so the target can decode the address, and only then raises its request.

The target acknowledges once it has stored write data, or once it is driving read data. The master drops its request, and on a read it latches the returned word at that same edge. The target then drops its acknowledge, which ends the transfer.

Addresses beyond the register file are never acknowledged. For those, a timeout in the master withdraws the request and flags an error.

Top module: `hs4_bus_pair`

## Requirements
- R1: After reset, busy, done, err, bus_req and bus_ack are low, rd_data is zero, and every target register reads back as zero.
- R2: A command accepted while idle (cmd_valid high and busy low at a clock edge) raises bus_req exactly DECODE_CYC clock edges after the accepting edge. The bus address stays unchanged while bus_req is high.
- R3: bus_ack rises only while bus_req is high. A write (cmd_write=1) to a register address below NUM_REGS is stored by the time bus_ack rises.
- R4: bus_req falls only while bus_ack is high, or on a timeout abort. bus_ack falls only after bus_req is low.
- R5: A new bus_req rises only while bus_ack is low, and the bus address changes only when bus_ack was low in the previous cycle.
- R6: The target drives read data (its output enable high) only while bus_ack is high. On a read (cmd_write=0), rd_data takes the addressed register's value at the edge where bus_req falls, and holds it afterwards.
- R7: busy is high from the cycle after acceptance until the transfer ends. done is then high for exactly one cycle, with busy already low.
- R8: cmd_valid is ignored while busy is high; a command issued then changes no register.
- R9: An access to an address at or above NUM_REGS receives no bus_ack. bus_req stays high for TIMEOUT_CYC cycles and then falls, and err is set together with the done pulse. err stays set until the next command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, taken only when idle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Register address |
| cmd_wdata | input | DATA_W | Write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err | output | 1 | Last transfer timed out |
| rd_data | output | DATA_W | Data latched by the last read |
| bus_req | output | 1 | Master request strobe (observation) |
| bus_ack | output | 1 | Target acknowledge strobe (observation) |

## Verification
The checker tests the strobe interlock on every cycle: acknowledge rises only under request, request falls only under acknowledge or an abort, acknowledge falls only after request, and a new request waits for acknowledge to clear. It also checks that the address holds while request is high, that the read enable never outlives acknowledge, and that done comes only just after busy.

Only the bench scenarios can show the values carried by the handshake: register contents after write and read sweeps, the exact settling and timeout cycle counts, the dropping of commands issued while busy, and the clearing of err.

// File: rtl/hs4_pkg.sv
package hs4_pkg;
   typedef enum logic [1:0] {
      M_IDLE,
      M_SETTLE,
      M_REQ,
      M_RELEASE
   } mst_state_t;

   typedef enum logic {
      S_IDLE,
      S_ACK
   } slv_state_t;
endpackage

// File: rtl/hs4_sync.sv
module hs4_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 1) begin : g_one
         logic r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= 1'b0;
            else        r <= d;
         end
         assign q = r;
      end else begin : g_chain
         logic [STAGES-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= '0;
            else        r <= {r[STAGES-2:0], d};
         end
         assign q = r[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/hs4_master.sv
module hs4_master
   import hs4_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int DATA_W      = 8,
   parameter int DECODE_CYC  = 2,
   parameter int TIMEOUT_CYC = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic              cmd_write,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_wdata,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic [DATA_W-1:0] rd_data,
   output logic              req,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_we,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              ack_s
);
   localparam int DCNT_W = $clog2(DECODE_CYC + 1);
   localparam int TCNT_W = $clog2(TIMEOUT_CYC + 1);
   localparam logic [DCNT_W-1:0] DLAST = DCNT_W'(DECODE_CYC - 1);
   localparam logic [TCNT_W-1:0] TLAST = TCNT_W'(TIMEOUT_CYC - 1);

   mst_state_t        state;
   logic [DCNT_W-1:0] dcnt;
   logic [TCNT_W-1:0] tcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= M_IDLE;
         dcnt      <= '0;
         tcnt      <= '0;
         done      <= 1'b0;
         err       <= 1'b0;
         rd_data   <= '0;
         bus_addr  <= '0;
         bus_we    <= 1'b0;
         bus_wdata <= '0;
      end else begin
         done <= 1'b0;
         case (state)
            M_IDLE: begin
               if (cmd_valid) begin
                  bus_addr  <= cmd_addr;
                  bus_we    <= cmd_write;
                  bus_wdata <= cmd_wdata;
                  err       <= 1'b0;
                  dcnt      <= '0;
                  state     <= M_SETTLE;
               end
            end
            M_SETTLE: begin
               if (dcnt == DLAST) begin
                  tcnt  <= '0;
                  state <= M_REQ;
               end else begin
                  dcnt <= dcnt + 1'b1;
               end
            end
            M_REQ: begin
               if (ack_s) begin
                  if (!bus_we) rd_data <= bus_rdata;
                  state <= M_RELEASE;
               end else if (tcnt == TLAST) begin
                  err   <= 1'b1;
                  done  <= 1'b1;
                  state <= M_IDLE;
               end else begin
                  tcnt <= tcnt + 1'b1;
               end
            end
            M_RELEASE: begin
               if (!ack_s) begin
                  done  <= 1'b1;
                  state <= M_IDLE;
               end
            end
            default: state <= M_IDLE;
         endcase
      end
   end

   assign busy = (state != M_IDLE);
   assign req  = (state == M_REQ);
endmodule

// File: rtl/hs4_slave.sv
module hs4_slave
   import hs4_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int DATA_W   = 8,
   parameter int NUM_REGS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_s,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic              ack,
   output logic              rd_oe,
   output logic [DATA_W-1:0] rd_word
);
   localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

   slv_state_t        state;
   logic [DATA_W-1:0] regs [NUM_REGS];
   logic              hit;
   logic [IDX_W-1:0]  idx;

   assign hit = (32'(bus_addr) < NUM_REGS);
   assign idx = IDX_W'(bus_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         rd_oe   <= 1'b0;
         rd_word <= '0;
         for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
      end else begin
         case (state)
            S_IDLE: begin
               if (req_s && hit) begin
                  if (bus_we) begin
                     regs[idx] <= bus_wdata;
                  end else begin
                     rd_word <= regs[idx];
                     rd_oe   <= 1'b1;
                  end
                  state <= S_ACK;
               end
            end
            S_ACK: begin
               if (!req_s) begin
                  rd_oe <= 1'b0;
                  state <= S_IDLE;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   assign ack = (state == S_ACK);
endmodule

// File: rtl/hs4_bus_pair.sv
module hs4_bus_pair #(
   parameter int ADDR_W      = 4,
   parameter int DATA_W      = 8,
   parameter int NUM_REGS    = 8,
   parameter int DECODE_CYC  = 2,
   parameter int TIMEOUT_CYC = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic              cmd_write,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_wdata,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic [DATA_W-1:0] rd_data,
   output logic              bus_req,
   output logic              bus_ack
);
   generate
      if (DECODE_CYC < 1)              begin : g_bad_dec  $error("DECODE_CYC must be >= 1"); end
      if (TIMEOUT_CYC < 1)             begin : g_bad_tmo  $error("TIMEOUT_CYC must be >= 1"); end
      if (SYNC_STAGES < 1)             begin : g_bad_sync $error("SYNC_STAGES must be >= 1"); end
      if (NUM_REGS > (1 << ADDR_W))    begin : g_bad_regs $error("NUM_REGS exceeds address space"); end
   endgenerate

   logic              req_s, ack_s;
   logic [ADDR_W-1:0] m_addr;
   logic              m_we;
   logic [DATA_W-1:0] m_wdata;
   logic              s_oe;
   logic [DATA_W-1:0] s_word;
   logic [DATA_W-1:0] bus_rdata;

   assign bus_rdata = s_oe ? s_word : '0;

   hs4_master #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .DECODE_CYC(DECODE_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
   ) u_mst (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_write(cmd_write),
      .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
      .busy(busy), .done(done), .err(err), .rd_data(rd_data),
      .req(bus_req), .bus_addr(m_addr), .bus_we(m_we),
      .bus_wdata(m_wdata), .bus_rdata(bus_rdata), .ack_s(ack_s)
   );

   hs4_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk(clk), .rst_n(rst_n), .d(bus_req), .q(req_s)
   );

   hs4_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
      .clk(clk), .rst_n(rst_n), .d(bus_ack), .q(ack_s)
   );

   hs4_slave #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)
   ) u_slv (
      .clk(clk), .rst_n(rst_n), .req_s(req_s),
      .bus_addr(m_addr), .bus_we(m_we), .bus_wdata(m_wdata),
      .ack(bus_ack), .rd_oe(s_oe), .rd_word(s_word)
   );
endmodule

// File: rtl/hs4_bus_pair_chk.sv
module hs4_bus_pair_chk #(
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_req,
   input logic              bus_ack,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              rd_oe,
   input logic              busy,
   input logic              done,
   input logic              err
);
   AST_ADDR_HELD_UNDER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> $stable(bus_addr)); // R2

   AST_ACK_ONLY_UNDER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_ack) |-> bus_req); // R3

   AST_REQ_DROP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_req) |-> (bus_ack || err)); // R4

   AST_ACK_DROP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_ack) |-> !bus_req); // R4

   AST_NEW_REQ_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_req) |-> !bus_ack); // R5

   AST_ADDR_MOVES_ACK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(bus_addr) |-> !$past(bus_ack)); // R5

   AST_OE_ONLY_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      rd_oe |-> bus_ack); // R6

   AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(busy) && !busy)); // R7
endmodule

bind hs4_bus_pair hs4_bus_pair_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_ack(bus_ack),
   .bus_addr(m_addr), .rd_oe(s_oe), .busy(busy), .done(done), .err(err)
);

// File: tb/hs4_bus_pair_tb.sv
module hs4_bus_pair_tb;
   localparam int ADDR_W = 4;
   localparam int DATA_W = 8;
   localparam int NREG   = 8;
   localparam int DEC    = 2;
   localparam int TMO    = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cmd_valid = 1'b0;
   logic              cmd_write = 1'b0;
   logic [ADDR_W-1:0] cmd_addr = '0;
   logic [DATA_W-1:0] cmd_wdata = '0;
   logic              busy, done, err, bus_req, bus_ack;
   logic [DATA_W-1:0] rd_data;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   bit finished = 0;

   int v_r3 = 0, v_r4 = 0, v_r5 = 0, hs_cnt = 0;
   logic p_req = 0, p_ack = 0;
   logic [DATA_W-1:0] rd_at_fall = '0;

   always #4 clk = ~clk;

   hs4_bus_pair #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NREG),
      .DECODE_CYC(DEC), .TIMEOUT_CYC(TMO), .SYNC_STAGES(2)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
      .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
      .err(err), .rd_data(rd_data), .bus_req(bus_req), .bus_ack(bus_ack)
   );

   task automatic check(input string req, input longint act, input longint exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [DATA_W-1:0] pat(input int i, input int salt);
      return DATA_W'((i * 37 + 5 + salt) % 256);
   endfunction

   // port monitor for the strobe interlock
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (bus_ack && !p_ack && !p_req) v_r3++;             // R3
         if (!bus_req && p_req && !p_ack && !err) v_r4++;     // R4
         if (!bus_ack && p_ack && bus_req) v_r4++;            // R4
         if (bus_req && !p_req && p_ack) v_r5++;              // R5
         if (!bus_req && p_req) rd_at_fall = rd_data;         // R6
         if (bus_ack && !p_ack) hs_cnt++;
      end
      p_req = bus_req;
      p_ack = bus_ack;
   end

   always @(negedge clk) begin
      if (!finished && cyc > 100000) begin
         finished = 1;
         bad++; total++;
         $display("FAIL watchdog actual=%0d expected=<100000", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic do_cmd(input logic we, input int addr, input logic [DATA_W-1:0] d);
      while (busy) @(negedge clk);
      cmd_valid = 1'b1; cmd_write = we; cmd_addr = ADDR_W'(addr); cmd_wdata = d;
      @(negedge clk);
      cmd_valid = 1'b0;
      while (!done) @(negedge clk);
   endtask

   initial begin
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 busy", busy, 0);
      check("R1 done", done, 0);
      check("R1 err", err, 0);
      check("R1 req", bus_req, 0);
      check("R1 ack", bus_ack, 0);
      check("R1 rd_data", rd_data, 0);
      for (int i = 0; i < NREG; i++) begin
         do_cmd(1'b0, i, '0);
         check("R1 reg zero", rd_data, 0);
      end

      // R2 settling latency, R7 busy/done
      while (busy) @(negedge clk);
      cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = 4'd0; cmd_wdata = 8'h11;
      n = 0;
      forever begin
         @(posedge clk); n++;
         @(negedge clk);
         cmd_valid = 1'b0;
         if (n == 1) check("R7 busy after accept", busy, 1);
         if (bus_req || n > 20) break;
      end
      check("R2 req latency", n, DEC + 1);
      while (!done) @(negedge clk);
      check("R7 busy low at done", busy, 0);
      @(negedge clk);
      check("R7 done one cycle", done, 0);

      // R3/R6 write then read sweep, two patterns
      for (int s = 0; s < 2; s++) begin
         for (int i = 0; i < NREG; i++) do_cmd(1'b1, i, pat(i, s * 101));
         for (int i = NREG - 1; i >= 0; i--) begin
            do_cmd(1'b0, i, 8'hFF);
            check("R3 write stored", rd_data, pat(i, s * 101));
            check("R6 latched at req fall", rd_at_fall, pat(i, s * 101));
         end
      end

      // R8 command while busy is dropped
      do_cmd(1'b1, 3, 8'hAA);
      while (busy) @(negedge clk);
      cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = 4'd5; cmd_wdata = 8'h77;
      @(negedge clk);
      cmd_addr = 4'd3; cmd_wdata = 8'h55;
      repeat (3) @(negedge clk);
      cmd_valid = 1'b0;
      while (!done) @(negedge clk);
      @(negedge clk);
      do_cmd(1'b0, 3, '0);
      check("R8 busy cmd ignored", rd_data, 8'hAA);
      do_cmd(1'b0, 5, '0);
      check("R8 accepted cmd", rd_data, 8'h77);

      // R9 timeout on unmapped address
      while (busy) @(negedge clk);
      cmd_valid = 1'b1; cmd_write = 1'b0; cmd_addr = 4'd12; cmd_wdata = '0;
      @(negedge clk);
      cmd_valid = 1'b0;
      while (!bus_req) @(negedge clk);
      n = 1;
      @(negedge clk);
      while (bus_req && n < 100) begin n++; @(negedge clk); end
      check("R9 req hold", n, TMO);
      check("R9 err set", err, 1);
      check("R9 done with err", done, 1);
      check("R9 read kept", rd_data, 8'h77);
      @(negedge clk);
      check("R9 err sticky", err, 1);
      do_cmd(1'b0, 5, '0);
      check("R9 err cleared", err, 0);

      // interlock monitors
      check("R3 ack without req", v_r3, 0);
      check("R4 early release", v_r4, 0);
      check("R5 req over ack", v_r5, 0);
      check("R3 handshakes seen", (hs_cnt > 20), 1);

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule